// File: doc/BRIEF.md
# Multi-CPU Interrupt Routing Controller

The block takes a vector of level-sensitive interrupt sources and steers each one to one output pin of one CPU. Every source has an enable bit that must be set when the source rises for the event to count. A per-source map byte picks the target CPU, and a per-group map byte picks the output pin on that CPU. The route is latched when the source rises. Each CPU owns a private bank of status words. A CPU reads its bank, and clears bits in it by writing ones.

Software reaches the block through a 32-bit register port. Every access carries a requester ID. For the status range, that ID selects the bank, not any address bit. An output pin is high while at least one source routed to it is still pending. The pin therefore changes level only when its pending set goes from empty to non-empty, or from non-empty to empty. The source count, CPU count (1 to 8) and pins per CPU are parameters. The defaults are 64 sources, 4 CPUs and 4 pins per CPU.

Top module: `irq_route_ctl`

## Requirements
- R1: A rising source whose enable bit is 0 is ignored. No status bit is set, no pending bit is set and no output pin moves.
- R2: An enabled source n that rises sets bit n%32 of status word n/32 in its target CPU's bank, and marks the source pending. The status word sits at byte offset 0x400 + 4*(n/32). The routed pin goes high after the clock edge that samples the rise.
- R3: Output pin p of CPU c is irq_o[c*N_PIN+p]. It stays high while any pending source is routed to it, and goes low only when the last such source leaves.
- R4: A source falling clears its status bit in the bank it was routed to, and clears its pending bit.
- R5: The core-map byte for source n is byte n%4 of the word at 0x800 + 4*(n/4), in little-endian order. The lowest set bit among bits [N_CPU-1:0] selects the CPU. If none of those bits is set, CPU 0 is selected.
- R6: The pin-map byte for group g (sources 32g..32g+31) is byte g%4 of the word at 0x4C0 + 4*(g/4). The lowest set bit among bits [N_PIN-1:0] selects the pin. If none is set, pin 0 is selected.
- R7: Status reads and writes use the bank named by rid_i. A requester ID of N_CPU or more reads 0, and its writes change nothing.
- R8: A write to a status word clears each status bit that was set and written as 1. Of those bits, only the lowest one also drops its source's pending state. A write that hits no set bit changes nothing.
- R9: The enable word for group g is at 0x600 + 4*g, and bit k of that word enables source 32g+k. Read data appears on rdata_o after the clock edge that takes the read request, and holds until the next read.
- R10: A write to an offset outside the enable, pin-map, core-map and status ranges changes nothing. A read of such an offset returns 0. Address bits [1:0] are ignored.
- R11: Reset (rst_ni low, asynchronous) drives every output pin low. It also clears all enables, maps, status and pending state, and the edge-detect history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | N_SRC | Level-sensitive interrupt sources |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address within the register window |
| wdata_i | input | 32 | Write data |
| rid_i | input | RID_W | Requester ID of the access |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | N_CPU*N_PIN | Output pins, CPU-major |

## Verification
The assertions check the following on every cycle:
- An ignored rise never creates pending state.
- An enabled rise always leaves the source pending.
- A fall always clears it.
- A clear-by-write leaves no written bit set in the addressed bank.
- A write to an unmapped offset leaves the configuration untouched.

Only the bench scenarios can show the rest:
- Routing picks the lowest valid map bit, and falls back to CPU 0 or pin 0 when no valid bit is set.
- Banks stay isolated across requester IDs.
- Only the lowest cleared bit drops a pending source.
- A pin shared by two sources holds its level until the second one leaves.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned DW       = 32;
  localparam int unsigned GRP_SRC  = 32;
  // word addresses (byte offset >> 2)
  localparam logic [9:0] ST_WA = 10'h100;  // 0x400 status
  localparam logic [9:0] PM_WA = 10'h130;  // 0x4C0 pin map
  localparam logic [9:0] EN_WA = 10'h180;  // 0x600 enable
  localparam logic [9:0] CM_WA = 10'h200;  // 0x800 core map
endpackage

// File: rtl/irq_route_cfg.sv
module irq_route_cfg
  import irq_route_pkg::*;
#(
  parameter int unsigned N_SRC = 64,
  parameter int unsigned N_CPU = 4,
  parameter int unsigned N_PIN = 4,
  localparam int unsigned N_GRP = N_SRC / GRP_SRC,
  localparam int unsigned CW    = (N_CPU > 1) ? $clog2(N_CPU) : 1,
  localparam int unsigned PW    = (N_PIN > 1) ? $clog2(N_PIN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [9:0]       waddr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic [N_SRC-1:0] en_o,
  output logic [CW-1:0]    cpu_o [N_SRC],
  output logic [PW-1:0]    pin_o [N_SRC]
);
  localparam int unsigned PM_WORDS = (N_GRP + 3) / 4;
  localparam int unsigned CM_WORDS = N_SRC / 4;

  logic [N_SRC-1:0]        en_q;
  logic [7:0]              pmap_q [N_GRP];
  logic [7:0]              cmap_q [N_SRC];
  logic [PM_WORDS*DW-1:0]  pm_flat;
  logic [N_SRC*8-1:0]      cm_flat;
  logic                    map_hit;

  function automatic logic [CW-1:0] pick_cpu(input logic [7:0] b);
    logic [CW-1:0] r = '0;
    for (int k = N_CPU - 1; k >= 0; k--) if (b[k]) r = CW'(k);
    return r;
  endfunction

  function automatic logic [PW-1:0] pick_pin(input logic [7:0] b);
    logic [PW-1:0] r = '0;
    for (int k = N_PIN - 1; k >= 0; k--) if (b[k]) r = PW'(k);
    return r;
  endfunction

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[g*GRP_SRC +: GRP_SRC] <= '0;
        pmap_q[g]                  <= '0;
      end else begin
        if (wr_i && waddr_i == 10'(EN_WA + g)) en_q[g*GRP_SRC +: GRP_SRC] <= wdata_i;
        if (wr_i && waddr_i == 10'(PM_WA + g / 4)) pmap_q[g] <= wdata_i[(g%4)*8 +: 8];
      end
    end
    assign pm_flat[g*8 +: 8] = pmap_q[g];
  end

  if (PM_WORDS * 4 > N_GRP) begin : g_pm_pad
    assign pm_flat[PM_WORDS*DW-1:N_GRP*8] = '0;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cmap_q[i] <= '0;
      else if (wr_i && waddr_i == 10'(CM_WA + i / 4)) cmap_q[i] <= wdata_i[(i%4)*8 +: 8];
    end
    assign cm_flat[i*8 +: 8] = cmap_q[i];
    assign en_o[i]  = en_q[i];
    assign cpu_o[i] = pick_cpu(cmap_q[i]);
    assign pin_o[i] = pick_pin(pmap_q[i / GRP_SRC]);
  end

  always_comb begin
    rdata_o = '0;
    map_hit = 1'b0;
    for (int g = 0; g < N_GRP; g++)
      if (waddr_i == 10'(EN_WA + g)) begin
        rdata_o = en_q[g*GRP_SRC +: GRP_SRC];
        map_hit = 1'b1;
      end
    for (int w = 0; w < PM_WORDS; w++)
      if (waddr_i == 10'(PM_WA + w)) begin
        rdata_o = pm_flat[w*DW +: DW];
        map_hit = 1'b1;
      end
    for (int w = 0; w < CM_WORDS; w++)
      if (waddr_i == 10'(CM_WA + w)) begin
        rdata_o = cm_flat[w*DW +: DW];
        map_hit = 1'b1;
      end
  end

  // R10: unmapped writes leave configuration alone
  a_r10_unmapped_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !map_hit) |=> ($stable(en_q) && $stable(cm_flat) && $stable(pm_flat)));
endmodule

// File: rtl/irq_route_track.sv
module irq_route_track
  import irq_route_pkg::*;
#(
  parameter int unsigned N_SRC = 64,
  parameter int unsigned N_CPU = 4,
  parameter int unsigned N_PIN = 4,
  localparam int unsigned N_GRP = N_SRC / GRP_SRC,
  localparam int unsigned CW    = (N_CPU > 1) ? $clog2(N_CPU) : 1,
  localparam int unsigned PW    = (N_PIN > 1) ? $clog2(N_PIN) : 1,
  localparam int unsigned GW    = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_SRC-1:0]       src_i,
  input  logic [N_SRC-1:0]       en_i,
  input  logic [CW-1:0]          cpu_i [N_SRC],
  input  logic [PW-1:0]          pin_i [N_SRC],
  input  logic                   clr_vld_i,
  input  logic [CW-1:0]          clr_cpu_i,
  input  logic [GW-1:0]          clr_word_i,
  input  logic [DW-1:0]          clr_mask_i,
  output logic [N_SRC-1:0]       stat_o [N_CPU],
  output logic [N_CPU*N_PIN-1:0] irq_o
);
  logic [N_SRC-1:0] src_q, pend_q, rise, fall, hit, kill;
  logic [CW-1:0]    rcpu_q [N_SRC];
  logic [PW-1:0]    rpin_q [N_SRC];
  logic [N_SRC-1:0] stat_q [N_CPU];
  logic             found;

  assign rise = src_i & ~src_q;
  assign fall = ~src_i & src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else         src_q <= src_i;
  end

  // bits set and written 1 in the addressed bank; lowest one drops its pending state
  always_comb begin
    hit   = '0;
    kill  = '0;
    found = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      hit[i] = clr_vld_i && clr_word_i == GW'(i / GRP_SRC) &&
               clr_mask_i[i % GRP_SRC] && stat_q[clr_cpu_i][i];
      if (hit[i] && !found) begin
        kill[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[i] <= 1'b0;
        rcpu_q[i] <= '0;
        rpin_q[i] <= '0;
      end else if (rise[i] && en_i[i]) begin
        pend_q[i] <= 1'b1;
        rcpu_q[i] <= cpu_i[i];
        rpin_q[i] <= pin_i[i];
      end else if (fall[i] || kill[i]) begin
        pend_q[i] <= 1'b0;
      end
    end

    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                         stat_q[c][i] <= 1'b0;
        else if (rise[i] && en_i[i] && cpu_i[i] == CW'(c))   stat_q[c][i] <= 1'b1;
        else if (fall[i] && rcpu_q[i] == CW'(c))             stat_q[c][i] <= 1'b0;
        else if (hit[i] && clr_cpu_i == CW'(c))              stat_q[c][i] <= 1'b0;
      end
    end

    a_r1_ignore_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rise[i] && !en_i[i] && !pend_q[i]) |=> !pend_q[i]);
    a_r2_rise_pends: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rise[i] && en_i[i]) |=> pend_q[i]);
    a_r4_fall_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall[i] |=> !pend_q[i]);
  end

  for (genvar c = 0; c < N_CPU; c++) begin : g_bank
    assign stat_o[c] = stat_q[c];
    for (genvar g = 0; g < N_GRP; g++) begin : g_word
      // R8: after a clear with no new rise, no written bit remains set
      a_r8_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_vld_i && clr_cpu_i == CW'(c) && clr_word_i == GW'(g) && rise == '0)
        |=> ((stat_q[c][g*GRP_SRC +: GRP_SRC] & $past(clr_mask_i)) == '0));
    end
  end

  always_comb begin
    irq_o = '0;
    for (int c = 0; c < N_CPU; c++)
      for (int p = 0; p < N_PIN; p++)
        for (int i = 0; i < N_SRC; i++)
          if (pend_q[i] && rcpu_q[i] == CW'(c) && rpin_q[i] == PW'(p))
            irq_o[c*N_PIN + p] = 1'b1;
  end
endmodule

// File: rtl/irq_route_ctl.sv
module irq_route_ctl
  import irq_route_pkg::*;
#(
  parameter int unsigned N_SRC = 64,
  parameter int unsigned N_CPU = 4,
  parameter int unsigned N_PIN = 4,
  parameter int unsigned RID_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_SRC-1:0]       src_i,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [11:0]            addr_i,
  input  logic [31:0]            wdata_i,
  input  logic [RID_W-1:0]       rid_i,
  output logic [31:0]            rdata_o,
  output logic [N_CPU*N_PIN-1:0] irq_o
);
  localparam int unsigned N_GRP = N_SRC / GRP_SRC;
  localparam int unsigned CW    = (N_CPU > 1) ? $clog2(N_CPU) : 1;
  localparam int unsigned PW    = (N_PIN > 1) ? $clog2(N_PIN) : 1;
  localparam int unsigned GW    = (N_GRP > 1) ? $clog2(N_GRP) : 1;

  if (N_CPU < 1 || N_CPU > 8 || N_PIN < 1 || N_PIN > 8 ||
      N_SRC % GRP_SRC != 0 || N_GRP < 1 || N_GRP > 48) begin : g_bad_cfg
    $error("irq_route_ctl: unsupported parameter set");
  end

  logic [9:0]       waddr;
  logic [1:0]       unused_byte_sel;
  logic [9:0]       st_off;
  logic             st_hit, rid_ok, clr_vld;
  logic [DW-1:0]    cfg_rdata, rdata_q;
  logic [N_SRC-1:0] en;
  logic [CW-1:0]    cpu_sel [N_SRC];
  logic [PW-1:0]    pin_sel [N_SRC];
  logic [N_SRC-1:0] stat [N_CPU];

  assign waddr           = addr_i[11:2];
  assign unused_byte_sel = addr_i[1:0];
  assign st_off          = waddr - ST_WA;
  assign st_hit          = st_off < 10'(N_GRP);
  assign rid_ok          = rid_i < RID_W'(N_CPU);
  assign clr_vld         = req_i && we_i && st_hit && rid_ok;

  irq_route_cfg #(.N_SRC(N_SRC), .N_CPU(N_CPU), .N_PIN(N_PIN)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (req_i && we_i),
    .waddr_i (waddr),
    .wdata_i (wdata_i),
    .rdata_o (cfg_rdata),
    .en_o    (en),
    .cpu_o   (cpu_sel),
    .pin_o   (pin_sel)
  );

  irq_route_track #(.N_SRC(N_SRC), .N_CPU(N_CPU), .N_PIN(N_PIN)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (src_i),
    .en_i       (en),
    .cpu_i      (cpu_sel),
    .pin_i      (pin_sel),
    .clr_vld_i  (clr_vld),
    .clr_cpu_i  (rid_i[CW-1:0]),
    .clr_word_i (st_off[GW-1:0]),
    .clr_mask_i (wdata_i),
    .stat_o     (stat),
    .irq_o      (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (req_i && !we_i) begin
      if (st_hit) rdata_q <= rid_ok ? stat[rid_i[CW-1:0]][st_off[GW-1:0]*GRP_SRC +: GRP_SRC] : '0;
      else        rdata_q <= cfg_rdata;
    end
  end
  assign rdata_o = rdata_q;
endmodule

// File: tb/irq_route_ctl_tb.sv
`timescale 1ns/1ps
module irq_route_ctl_tb;
  localparam int N_SRC = 64, N_CPU = 4, N_PIN = 4, RID_W = 8;
  localparam int NV = 10;
  localparam logic [11:0] T_ADDR [NV] = '{12'h600, 12'h604, 12'h608, 12'h4C0, 12'h800,
                                          12'h83C, 12'h840, 12'h100, 12'h8FC, 12'h400};
  localparam logic [31:0] T_WD   [NV] = '{32'hFFFF_FFFF, 32'h0000_FFFF, 32'h1234_5678,
                                          32'hFFFF_FFFF, 32'h0102_0408, 32'hA5A5_A5A5,
                                          32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                                          32'hFFFF_FFFF};
  localparam logic [31:0] T_EXP  [NV] = '{32'hFFFF_FFFF, 32'h0000_FFFF, 32'h0,
                                          32'h0000_FFFF, 32'h0102_0408, 32'hA5A5_A5A5,
                                          32'h0, 32'h0, 32'h0, 32'h0};

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [N_SRC-1:0] src = '0;
  logic req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [RID_W-1:0] rid = '0;
  logic [N_CPU*N_PIN-1:0] irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_route_ctl #(.N_SRC(N_SRC), .N_CPU(N_CPU), .N_PIN(N_PIN), .RID_W(RID_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rid_i(rid), .rdata_o(rdata), .irq_o(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input int r);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d; rid = RID_W'(r);
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [11:0] a, input int r, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a; rid = RID_W'(r);
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic set_src(input int i, input logic v);
    @(negedge clk); src[i] = v;
    @(negedge clk);
  endtask

  task automatic chk_irq(input string tag, input logic [31:0] exp);
    chk(tag, 32'(irq), exp);
  endtask

  task automatic chk_rd(input string tag, input logic [11:0] a, input int r, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, r, d);
    chk(tag, d, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_irq("R11 irq low in reset", 0);
    rst_ni = 1'b1;
    chk_rd("R11 enable cleared", 12'h600, 0, 0);
    chk_rd("R11 core map cleared", 12'h800, 0, 0);

    // R9 R6 R5 R10 register table
    for (int k = 0; k < NV; k++) begin
      wr(T_ADDR[k], T_WD[k], 0);
      chk_rd($sformatf("R9/R10 table %0d", k), T_ADDR[k], 0, T_EXP[k]);
    end
    wr(12'h600, 0, 0); wr(12'h604, 0, 0); wr(12'h4C0, 0, 0);
    for (int w = 0; w < N_SRC / 4; w++) wr(12'(12'h800 + 4 * w), 0, 0);

    // R1: disabled source ignored
    wr(12'h800, 32'h0000_0202, 0);  // src0,src1 -> cpu1
    wr(12'h4C0, 32'h0000_0A04, 0);  // g0 -> pin2, g1 -> pin1
    set_src(0, 1);
    chk_irq("R1 disabled no irq", 0);
    chk_rd("R1 disabled no status", 12'h400, 1, 0);
    set_src(0, 0);

    wr(12'h600, 32'hFFFF_FFFF, 0);
    wr(12'h604, 32'hFFFF_FEFF, 0);  // src40 disabled
    wr(12'h804, 32'h0000_8000, 0);  // src5: no valid cpu bit -> cpu0
    wr(12'h820, 32'h0000_0C00, 0);  // src33 -> cpu2

    // R2 / R7
    set_src(0, 1);
    chk_irq("R2 cpu1 pin2", 32'h40);
    chk_rd("R2 status bank1", 12'h400, 1, 1);
    chk_rd("R7 bank0 empty", 12'h400, 0, 0);
    chk_rd("R7 rid out of range reads 0", 12'h400, 4, 0);

    // R3 / R4 shared pin
    set_src(1, 1);
    chk_irq("R3 shared pin high", 32'h40);
    chk_rd("R2 two bits", 12'h400, 1, 3);
    set_src(0, 0);
    chk_irq("R3 pin held by src1", 32'h40);
    chk_rd("R4 src0 status cleared", 12'h400, 1, 2);
    set_src(1, 0);
    chk_irq("R3 pin low when empty", 0);
    chk_rd("R4 status empty", 12'h400, 1, 0);

    // R5 routing
    set_src(5, 1);
    chk_irq("R5 fallback cpu0 pin2", 32'h4);
    chk_rd("R5 status bit5 bank0", 12'h400, 0, 32'h20);
    set_src(33, 1);
    chk_irq("R5 lowest bit cpu2 pin1", 32'h204);
    chk_rd("R5 status word1 bank2", 12'h404, 2, 2);

    // R8 write-1-to-clear
    set_src(2, 1);
    chk_irq("R8 setup", 32'h204);
    chk_rd("R8 setup status", 12'h400, 0, 32'h24);
    wr(12'h400, 32'h24, 0);
    chk_rd("R8 both bits cleared", 12'h400, 0, 0);
    chk_irq("R8 only lowest drops pending", 32'h204);
    wr(12'h400, 32'h20, 0);
    chk_irq("R8 no-hit write no effect", 32'h204);

    // R7 bank isolation on writes
    wr(12'h404, 32'h2, 4);
    chk_rd("R7 out-of-range write ignored", 12'h404, 2, 2);
    wr(12'h404, 32'h2, 1);
    chk_rd("R7 other bank write ignored", 12'h404, 2, 2);
    chk_irq("R7 irq kept", 32'h204);
    wr(12'h404, 32'h2, 2);
    chk_rd("R8 bank2 cleared", 12'h404, 2, 0);
    chk_irq("R8 src33 pending dropped", 32'h4);

    set_src(5, 0);
    chk_irq("R4 fall drops pin", 0);
    set_src(2, 0);
    set_src(33, 0);
    chk_irq("R4 all low", 0);

    // R9 enable bit position
    set_src(40, 1);
    chk_irq("R9 src40 disabled", 0);
    chk_rd("R9 src40 no status", 12'h404, 0, 0);
    set_src(40, 0);
    set_src(41, 1);
    chk_irq("R9 src41 cpu0 pin1", 32'h2);
    chk_rd("R9 src41 status", 12'h404, 0, 32'h200);
    set_src(41, 0);
    chk_irq("R9 src41 released", 0);

    // R6 pin map with no valid bit
    wr(12'h4C0, 32'h0000_0AF0, 0);
    set_src(0, 1);
    chk_irq("R6 fallback pin0 cpu1", 32'h10);

    // R11 reset mid-run
    @(negedge clk); rst_ni = 1'b0;
    #1 chk_irq("R11 async reset drops pins", 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk_irq("R11 high source ignored after reset", 0);
    chk_rd("R11 enable cleared", 12'h600, 0, 0);
    chk_rd("R11 status cleared", 12'h400, 1, 0);
    set_src(0, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule